// File: doc/BRIEF.md
# Call/Return Program Counter Unit

This block sequences the fetch address of a small pipelined controller core. Each cycle it receives one instruction class from decode. It then either steps the fetch address, jumps to an absolute target, or enters or leaves a subroutine. Subroutine linkage uses a private eight-entry return-address stack. No instruction can address this stack or its pointer. They change only as a side effect of calls and returns.

Targets are 13 bits wide. The low 11 bits come from the instruction word. The top two bits come from a page-select register. Every accepted control transfer is followed by one flush cycle, in which the instruction already in the pipeline is discarded. The return-with-literal form also hands an 8-bit constant to the working register.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first instruction is applied, the following hold: `fetch_addr` = 000h, `flush` = 0 and `w_we` = 0. The stack pointer is 0, so the first call fills entry 0. Stack contents are not initialised.
- R2: The `op_kind` encoding is 0 = step, 1 = jump, 2 = call, 3 = return, 4 = return-with-literal. Codes 5 to 7 act as step. A step outside a flush cycle raises `fetch_addr` by one modulo 2^13, so 1FFFh is followed by 0000h.
- R3: A jump or call sets `fetch_addr`, one clock later, to `{page_sel[4:3], target[10:0]}`. The other page bits have no effect.
- R4: A call saves the current `fetch_addr` on the stack. This is the address of the instruction after the call. It then moves the pointer up by one.
- R5: A return moves the pointer down by one and loads the saved entry into `fetch_addr`. Nested calls up to eight deep, including repeated calls into the same routine, return in exact reverse order.
- R6: A return-with-literal behaves like a return. In the following cycle it also raises `w_we` for exactly one cycle, with `w_data` equal to the literal. `w_we` is never high at any other time.
- R7: Each accepted jump, call or return raises `flush` for exactly the next cycle. During that cycle `fetch_addr` advances by one.
- R8: Any op presented while `flush` is high is ignored. A call, return or jump in that cycle changes neither the stack nor the destination.
- R9: The pointer wraps modulo 8 without any flag. A ninth nested call overwrites the oldest entry, so after nine calls the ninth return yields the ninth saved address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind | input | 3 | Instruction class for this cycle |
| target | input | 11 | Absolute target field from the instruction word |
| page_sel | input | 8 | Page-select register, bits 4:3 used |
| literal | input | 8 | Literal of a return-with-literal |
| fetch_addr | output | 13 | Program fetch address |
| flush | output | 1 | Discard the instruction fetched last cycle |
| w_we | output | 1 | Working register write strobe |
| w_data | output | 8 | Working register write data |

## Verification
A wrong stack pointer or a corrupted stack entry does not show at the ports while code runs straight or jumps. It appears only at the next return, as a wrong `fetch_addr` in the cycle after that return. Deep nesting and the wrap to a ninth level are therefore exercised by unwinding every level and comparing each landing address. A missed or doubled flush shows within one cycle, either as a second transfer being obeyed or as a step lost.

// File: rtl/pc_seq_unit.sv
module pc_seq_unit #(
  parameter int AW      = 13,
  parameter int FW      = 11,
  parameter int DW      = 8,
  parameter int PW      = 8,
  parameter int DEPTH   = 8,
  parameter int PSEL_LO = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_kind,
  input  logic [FW-1:0] target,
  input  logic [PW-1:0] page_sel,
  input  logic [DW-1:0] literal,
  output logic [AW-1:0] fetch_addr,
  output logic          flush,
  output logic          w_we,
  output logic [DW-1:0] w_data
);
  localparam int SPW = $clog2(DEPTH);
  localparam int HW  = AW - FW;

  localparam logic [2:0] OP_JUMP = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;
  localparam logic [2:0] OP_RETL = 3'd4;

  logic [AW-1:0]  pc_q;
  logic [SPW-1:0] sp_q;
  logic [AW-1:0]  stk [DEPTH];
  logic           flush_q;
  logic           we_q;
  logic [DW-1:0]  wd_q;

  wire live     = !flush_q;
  wire do_jump  = live && (op_kind == OP_JUMP);
  wire do_call  = live && (op_kind == OP_CALL);
  wire do_retl  = live && (op_kind == OP_RETL);
  wire do_ret   = live && ((op_kind == OP_RET) || (op_kind == OP_RETL));
  wire transfer = do_jump || do_call || do_ret;

  wire [AW-1:0]  dest  = {page_sel[PSEL_LO+HW-1:PSEL_LO], target};
  wire [SPW-1:0] sp_dn = sp_q - 1'b1;
  wire [SPW-1:0] sp_up = sp_q + 1'b1;
  wire [AW-1:0]  popped = stk[sp_dn];

  logic unused_page;
  assign unused_page = ^page_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      sp_q    <= '0;
      flush_q <= 1'b0;
      we_q    <= 1'b0;
      wd_q    <= '0;
    end else begin
      flush_q <= transfer;
      we_q    <= do_retl;
      if (do_retl) wd_q <= literal;
      if (do_jump || do_call) pc_q <= dest;
      else if (do_ret)        pc_q <= popped;
      else                    pc_q <= pc_q + 1'b1;
      if (do_call)     sp_q <= sp_up;
      else if (do_ret) sp_q <= sp_dn;
    end
  end

  always_ff @(posedge clk) begin
    if (do_call) stk[sp_q] <= pc_q;
  end

  assign fetch_addr = pc_q;
  assign flush      = flush_q;
  assign w_we       = we_q;
  assign w_data     = wd_q;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (op_kind == 3'd0 || op_kind > 3'd4)) |=> (fetch_addr == $past(fetch_addr) + 1'b1)); // R2
  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (op_kind == OP_JUMP || op_kind == OP_CALL)) |=>
      (fetch_addr == {$past(page_sel[PSEL_LO+HW-1:PSEL_LO]), $past(target)})); // R3
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush); // R7
  AST_FLUSH_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && op_kind >= 3'd1 && op_kind <= 3'd4) |=> flush); // R7
  AST_IGNORE_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fetch_addr == $past(fetch_addr) + 1'b1)); // R8
  AST_WRITE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && op_kind == OP_RETL) |=> (w_we && w_data == $past(literal))); // R6
  AST_WE_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    w_we |-> flush); // R6
endmodule

// File: tb/sim_pc_seq_unit.sv
module sim_pc_seq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_kind = 3'd0;
  logic [10:0] target = '0;
  logic [7:0]  page_sel = '0;
  logic [7:0]  literal = '0;
  logic [12:0] fetch_addr;
  logic        flush, w_we;
  logic [7:0]  w_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pc_seq_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .target(target),
    .page_sel(page_sel), .literal(literal), .fetch_addr(fetch_addr),
    .flush(flush), .w_we(w_we), .w_data(w_data)
  );

  // {op, target, page, literal, exp_fetch, exp_flush, exp_we, exp_wdata}
  localparam logic [52:0] VEC [18] = '{
    {3'd0, 11'h000, 8'h00, 8'h00, 13'h0001, 1'b0, 1'b0, 8'h00}, // R2
    {3'd0, 11'h000, 8'h00, 8'h00, 13'h0002, 1'b0, 1'b0, 8'h00}, // R2
    {3'd1, 11'h123, 8'h18, 8'h00, 13'h1923, 1'b1, 1'b0, 8'h00}, // R3 R7
    {3'd1, 11'h000, 8'h00, 8'h00, 13'h1924, 1'b0, 1'b0, 8'h00}, // R8
    {3'd2, 11'h050, 8'h08, 8'h00, 13'h0850, 1'b1, 1'b0, 8'h00}, // R4
    {3'd0, 11'h000, 8'h00, 8'h00, 13'h0851, 1'b0, 1'b0, 8'h00}, // R7
    {3'd2, 11'h200, 8'h00, 8'h00, 13'h0200, 1'b1, 1'b0, 8'h00}, // R4
    {3'd6, 11'h000, 8'h00, 8'h00, 13'h0201, 1'b0, 1'b0, 8'h00}, // R2
    {3'd4, 11'h000, 8'h00, 8'hFF, 13'h0851, 1'b1, 1'b1, 8'hFF}, // R6
    {3'd0, 11'h000, 8'h00, 8'h00, 13'h0852, 1'b0, 1'b0, 8'hFF}, // R6
    {3'd3, 11'h000, 8'h00, 8'h00, 13'h1924, 1'b1, 1'b0, 8'hFF}, // R5
    {3'd0, 11'h000, 8'h00, 8'h00, 13'h1925, 1'b0, 1'b0, 8'hFF}, // R2
    {3'd1, 11'h7FF, 8'hE7, 8'h00, 13'h07FF, 1'b1, 1'b0, 8'hFF}, // R3
    {3'd0, 11'h000, 8'h00, 8'h00, 13'h0800, 1'b0, 1'b0, 8'hFF}, // R2
    {3'd2, 11'h010, 8'h00, 8'h00, 13'h0010, 1'b1, 1'b0, 8'hFF}, // R4
    {3'd3, 11'h000, 8'h00, 8'h00, 13'h0011, 1'b0, 1'b0, 8'hFF}, // R8
    {3'd3, 11'h000, 8'h00, 8'h00, 13'h0800, 1'b1, 1'b0, 8'hFF}, // R5
    {3'd0, 11'h000, 8'h00, 8'h00, 13'h0801, 1'b0, 1'b0, 8'hFF}  // R2
  };

  logic [12:0] m_pc;
  logic [2:0]  m_sp;
  logic [12:0] m_stk [8];
  logic        m_fl;
  logic        m_we;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [10:0] t, input logic [7:0] p,
                       input logic [7:0] l);
    op_kind = op; target = t; page_sel = p; literal = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model(input logic [2:0] op, input logic [10:0] t, input logic [7:0] p);
    m_we = 1'b0;
    if (m_fl) begin
      m_pc = m_pc + 13'd1; m_fl = 1'b0;
    end else if (op == 3'd1) begin
      m_pc = {p[4:3], t}; m_fl = 1'b1;
    end else if (op == 3'd2) begin
      m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1; m_pc = {p[4:3], t}; m_fl = 1'b1;
    end else if (op == 3'd3 || op == 3'd4) begin
      m_sp = m_sp - 3'd1; m_pc = m_stk[m_sp]; m_fl = 1'b1; m_we = (op == 3'd4);
    end else begin
      m_pc = m_pc + 13'd1;
    end
  endtask

  task automatic apply(input string req, input logic [2:0] op, input logic [10:0] t,
                       input logic [7:0] p);
    model(op, t, p);
    drive(op, t, p, 8'h00);
    chk(req, 32'(fetch_addr), 32'(m_pc));
    chk(req, 32'(flush), 32'(m_fl));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op_kind = 3'd0;
    repeat (2) @(negedge clk);
    chk("R1", 32'(fetch_addr), 32'h0);
    chk("R1", 32'(flush), 32'h0);
    chk("R1", 32'(w_we), 32'h0);
    rst_n = 1'b1;
    m_pc = '0; m_sp = '0; m_fl = 1'b0; m_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    for (int i = 0; i < 18; i++) begin
      drive(VEC[i][52:50], VEC[i][49:39], VEC[i][38:31], VEC[i][30:23]);
      chk($sformatf("R2-R8 vector %0d fetch", i), 32'(fetch_addr), 32'(VEC[i][22:10]));
      chk($sformatf("R7 vector %0d flush", i), 32'(flush), 32'(VEC[i][9]));
      chk($sformatf("R6 vector %0d we", i), 32'(w_we), 32'(VEC[i][8]));
      if (VEC[i][8]) chk("R6 data", 32'(w_data), 32'(VEC[i][7:0]));
    end

    // R1: reset mid-run, then first call must land in entry 0 and return to it
    do_reset();
    apply("R1", 3'd0, 11'h0, 8'h0);
    apply("R1", 3'd2, 11'h333, 8'h10);
    apply("R1", 3'd0, 11'h0, 8'h0);
    apply("R1", 3'd3, 11'h0, 8'h0);
    apply("R1", 3'd0, 11'h0, 8'h0);

    // R5: eight nested levels, then unwind in reverse order
    for (int i = 0; i < 8; i++) begin
      apply("R5 call", 3'd2, 11'(11'h100 + i * 11'h020), 8'(i * 8));
      apply("R5 step", 3'd0, 11'h0, 8'h0);
    end
    for (int i = 0; i < 8; i++) begin
      apply("R5 return", 3'd3, 11'h0, 8'h0);
      apply("R5 step", 3'd0, 11'h0, 8'h0);
    end

    // R5: a routine calling itself three times
    apply("R5 self", 3'd2, 11'h400, 8'h00);
    for (int i = 0; i < 2; i++) begin
      apply("R5 self", 3'd0, 11'h0, 8'h0);
      apply("R5 self", 3'd2, 11'h400, 8'h00);
    end
    for (int i = 0; i < 3; i++) begin
      apply("R5 self", 3'd0, 11'h0, 8'h0);
      apply("R5 self", 3'd3, 11'h0, 8'h0);
    end
    apply("R5 self", 3'd0, 11'h0, 8'h0);

    // R9: nine nested calls overwrite the oldest entry
    for (int i = 0; i < 9; i++) begin
      apply("R9 call", 3'd2, 11'(11'h040 + i * 11'h011), 8'h18);
      apply("R9 step", 3'd0, 11'h0, 8'h0);
    end
    for (int i = 0; i < 9; i++) begin
      apply("R9 return", 3'd3, 11'h0, 8'h0);
      apply("R9 step", 3'd0, 11'h0, 8'h0);
    end

    // R2: wrap of the fetch address
    apply("R2 wrap", 3'd1, 11'h7FF, 8'h18);
    chk("R2 wrap", 32'(fetch_addr), 32'h1FFF);
    apply("R2 wrap", 3'd0, 11'h0, 8'h0);
    chk("R2 wrap", 32'(fetch_addr), 32'h0000);

    // R6: literal 00h, then no further write
    apply("R6", 3'd2, 11'h055, 8'h00);
    apply("R6", 3'd0, 11'h0, 8'h0);
    model(3'd4, 11'h0, 8'h0);
    drive(3'd4, 11'h0, 8'h0, 8'h00);
    chk("R6 we", 32'(w_we), 32'h1);
    chk("R6 data", 32'(w_data), 32'h00);
    chk("R6 pc", 32'(fetch_addr), 32'(m_pc));
    apply("R6", 3'd4, 11'h0, 8'h0);
    chk("R6 we ignored in flush", 32'(w_we), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule